// File: doc/BRIEF.md
# Quad-Channel Serial DAC Register Controller

This block is the digital control core of a four-channel voltage DAC. A host loads it through a three-wire serial port: an active-low select, a serial clock and a data line. Each frame carries two shutdown control bits, a two-bit channel address and a data code. The code is `DATA_W` bits wide: 12 by default, or 10 for the narrower variant. Frames are `DATA_W + 4` bits long.

When the select rises, the frame is decoded. Depending on its control bits, it writes the data code into the addressed channel's input register, or it powers down one channel or all of them. A second rank of DAC registers drives the analog side. This rank is fed from the input registers by a shared active-low, level-sensitive load strobe, so all four outputs can change together.

A power-on reset clears everything. An asynchronous clear returns all codes to zero and wakes every channel, but it leaves the serial shift register untouched. The select, load strobe and serial lines are asynchronous to the system clock, and the block synchronises them before they act.

Top module: `quad_dac_ctrl`

## Requirements
- R1: After power-on reset (`porN` low), every DAC code reads zero and every channel enable reads 1.
- R2: A frame is shifted most significant bit first, one bit per rising `serClk` edge while `selN` is low. Bit `DATA_W+3` is the all-off flag, bit `DATA_W+2` is the single-off flag, bits `DATA_W+1:DATA_W` are the channel address, and bits `DATA_W-1:0` are the code. On the rising edge of `selN`, only the last `DATA_W+4` bits shifted are decoded, so any earlier bits have no effect.
- R3: While `selN` is high, `serClk` edges do not change the shift register. A later `selN` low-high pulse with no clock edges re-decodes the word that was held.
- R4: A frame with both flags 0 writes its code into the input register of the addressed channel. Address 0 selects channel 0 (`dacCode[DATA_W-1:0]`), and channel n sits at bits `n*DATA_W +: DATA_W`. The DAC codes do not change while `loadN` stays high.
- R5: While `loadN` is low, every DAC register follows its input register. Once `loadN` is high, the DAC registers hold.
- R6: A frame with the all-off flag set drives all four enables to 0. With only the single-off flag set, only the addressed channel's enable drops. Neither kind of frame changes any input or DAC code.
- R7: A code-write frame sets the addressed channel's enable back to 1 and leaves the other enables unchanged.
- R8: While `clearN` is low, all DAC codes read zero and all enables read 1, without waiting for a clock. The shift register keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, clears all state |
| clearN | input | 1 | Asynchronous clear of codes and shutdown state, active low |
| serClk | input | 1 | Serial clock; data taken on its rising edge |
| serDin | input | 1 | Serial data in, MSB first |
| selN | input | 1 | Serial select, active low; rising edge commits the frame |
| loadN | input | 1 | Level-sensitive load strobe, active low |
| dacCode | output | 4*DATA_W | DAC register codes, channel n at bits n*DATA_W +: DATA_W |
| chanEn | output | 4 | Per-channel enable, 0 means shut down |

## Verification
The bench writes a different code to each of the four addresses. This separates a wrong address decode from a wrong data path. Holding `loadN` high, pulsing it, and holding it low tell apart the latch, the transparent and the hold behaviour of the second register rank. Frames split into two bytes and frames with extra leading bits show whether the decode uses only the last bits shifted. Clock edges given while the select is high, followed by a bare select pulse, show whether the shift register holds. Shutdown frames, code writes into sleeping channels, and an asynchronous clear given between clock edges separate enable handling from code handling.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NCH   = 4;
  localparam int ADR_W = 2;
  localparam int CMD_W = 2 + ADR_W;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic commit;
    logic loadActive;
  } qdac_strobe_t;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         porN,
  input  logic         serClk,
  input  logic         serDin,
  input  logic         selN,
  input  logic         loadN,
  output qdac_strobe_t strb
);
  localparam int         NIN     = 4;
  localparam logic [3:0] IDLE_IN = 4'b1100;

  logic [NIN-1:0] rawIn;
  logic [NIN-1:0] stage [SYNC_STAGES];
  logic [NIN-1:0] syncIn;
  logic           clkPrev, selPrev;

  assign rawIn = {loadN, selN, serDin, serClk};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) stage[s] <= IDLE_IN;
      else if (s == 0) stage[s] <= rawIn;
      else stage[s] <= stage[(s == 0) ? 0 : s - 1];
    end
  end

  assign syncIn = stage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      clkPrev <= 1'b0;
      selPrev <= 1'b1;
    end else begin
      clkPrev <= syncIn[0];
      selPrev <= syncIn[2];
    end
  end

  always_comb begin
    strb.shiftEn    = syncIn[0] & ~clkPrev & ~syncIn[2];
    strb.shiftBit   = syncIn[1];
    strb.commit     = syncIn[2] & ~selPrev;
    strb.loadActive = ~syncIn[3];
  end
endmodule

// File: rtl/qdac_path.sv
module qdac_path
  import qdac_pkg::*;
#(
  parameter  int DATA_W = 12,
  localparam int WORD_W = DATA_W + CMD_W
) (
  input  logic                    clk,
  input  logic                    porN,
  input  logic                    clearN,
  input  qdac_strobe_t            strb,
  output logic [WORD_W-1:0]       shiftWord,
  output logic [NCH*DATA_W-1:0]   inFlat,
  output logic [NCH*DATA_W-1:0]   dacFlat,
  output logic [NCH-1:0]          chanEn
);
  logic              regRstN;
  logic              cmdAll, cmdOne;
  logic [ADR_W-1:0]  cmdAddr;
  logic [DATA_W-1:0] cmdData;
  logic [DATA_W-1:0] inReg  [NCH];
  logic [DATA_W-1:0] dacReg [NCH];
  logic [NCH-1:0]    shut;

  assign regRstN = porN & clearN;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) shiftWord <= '0;
    else if (strb.shiftEn) shiftWord <= {shiftWord[WORD_W-2:0], strb.shiftBit};
  end

  assign cmdAll  = shiftWord[WORD_W-1];
  assign cmdOne  = shiftWord[WORD_W-2];
  assign cmdAddr = shiftWord[DATA_W +: ADR_W];
  assign cmdData = shiftWord[DATA_W-1:0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic hit;
    assign hit = (cmdAddr == ADR_W'(ch));

    always_ff @(posedge clk or negedge regRstN) begin
      if (!regRstN) begin
        inReg[ch]  <= '0;
        dacReg[ch] <= '0;
        shut[ch]   <= 1'b0;
      end else begin
        if (strb.commit) begin
          if (cmdAll) shut[ch] <= 1'b1;
          else if (hit && cmdOne) shut[ch] <= 1'b1;
          else if (hit) begin
            inReg[ch] <= cmdData;
            shut[ch]  <= 1'b0;
          end
        end
        if (strb.loadActive) dacReg[ch] <= inReg[ch];
      end
    end

    assign inFlat[ch*DATA_W +: DATA_W]  = inReg[ch];
    assign dacFlat[ch*DATA_W +: DATA_W] = dacReg[ch];
    assign chanEn[ch]                   = ~shut[ch];
  end
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import qdac_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  porN,
  input  logic                  clearN,
  input  logic                  serClk,
  input  logic                  serDin,
  input  logic                  selN,
  input  logic                  loadN,
  output logic [4*DATA_W-1:0]   dacCode,
  output logic [3:0]            chanEn
);
  localparam int WORD_W = DATA_W + CMD_W;

  qdac_strobe_t            strb;
  logic [WORD_W-1:0]       shiftWord;
  logic [NCH*DATA_W-1:0]   inFlat;

  qdac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .porN(porN), .serClk(serClk), .serDin(serDin),
    .selN(selN), .loadN(loadN), .strb(strb)
  );

  qdac_path #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .porN(porN), .clearN(clearN), .strb(strb),
    .shiftWord(shiftWord), .inFlat(inFlat), .dacFlat(dacCode), .chanEn(chanEn)
  );
endmodule

// File: rtl/qdac_check.sv
module qdac_check
  import qdac_pkg::*;
#(
  parameter  int DATA_W = 12,
  localparam int WORD_W = DATA_W + CMD_W
) (
  input logic                  clk,
  input logic                  porN,
  input logic                  clearN,
  input qdac_strobe_t          strb,
  input logic [WORD_W-1:0]     shiftWord,
  input logic [NCH*DATA_W-1:0] inFlat,
  input logic [NCH*DATA_W-1:0] dacFlat,
  input logic [NCH-1:0]        chanEn
);
  logic             fAll, fOne;
  logic [ADR_W-1:0] fAddr;
  assign fAll  = shiftWord[WORD_W-1];
  assign fOne  = shiftWord[WORD_W-2];
  assign fAddr = shiftWord[DATA_W +: ADR_W];

  AST_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (!porN)
    !strb.shiftEn |=> $stable(shiftWord)); // R3
  AST_DAC_HOLDS: assert property (@(posedge clk) disable iff (!porN || !clearN)
    !strb.loadActive |=> $stable(dacFlat)); // R5
  AST_DAC_FOLLOWS: assert property (@(posedge clk) disable iff (!porN || !clearN)
    strb.loadActive |=> dacFlat == $past(inFlat)); // R5
  AST_ALL_OFF: assert property (@(posedge clk) disable iff (!porN || !clearN)
    strb.commit && fAll |=> chanEn == '0); // R6
  AST_OFF_KEEPS_CODES: assert property (@(posedge clk) disable iff (!porN || !clearN)
    strb.commit && (fAll || fOne) |=> $stable(inFlat)); // R6
  AST_WRITE_WAKES: assert property (@(posedge clk) disable iff (!porN || !clearN)
    strb.commit && !fAll && !fOne |=> chanEn[$past(fAddr)]); // R7
  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!porN)
    !clearN |-> (dacFlat == '0) && (&chanEn)); // R8
endmodule

bind quad_dac_ctrl qdac_check #(.DATA_W(DATA_W)) u_check (
  .clk(clk), .porN(porN), .clearN(clearN), .strb(strb),
  .shiftWord(shiftWord), .inFlat(inFlat), .dacFlat(dacCode), .chanEn(chanEn)
);

// File: tb/quad_dac_ctrl_bench.sv
`timescale 1ns/1ps
module quad_dac_ctrl_bench;
  localparam int DW = 12;
  localparam int WW = DW + 4;

  logic          clk = 1'b0;
  logic          porN = 1'b0, clearN = 1'b1;
  logic          serClk = 1'b0, serDin = 1'b0, selN = 1'b1, loadN = 1'b1;
  logic [4*DW-1:0] dacCode;
  logic [3:0]    chanEn;
  int            checks = 0, errors = 0;

  quad_dac_ctrl #(.DATA_W(DW)) u_quad_dac_ctrl (
    .clk(clk), .porN(porN), .clearN(clearN), .serClk(serClk), .serDin(serDin),
    .selN(selN), .loadN(loadN), .dacCode(dacCode), .chanEn(chanEn)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] code(input int ch);
    return dacCode[ch*DW +: DW];
  endfunction

  function automatic logic [WW-1:0] frame(input logic all, input logic one,
                                          input logic [1:0] adr, input logic [DW-1:0] d);
    return {all, one, adr, d};
  endfunction

  task automatic clockBits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serDin = bits[i];
      #40 serClk = 1'b1;
      #40 serClk = 1'b0;
    end
  endtask

  task automatic sendBits(input logic [31:0] bits, input int n);
    selN = 1'b0;
    #40 clockBits(bits, n);
    #40 selN = 1'b1;
    #120;
  endtask

  task automatic sendWord(input logic [WW-1:0] w);
    sendBits(32'(w), WW);
  endtask

  task automatic pulseLoad();
    loadN = 1'b0;
    #80 loadN = 1'b1;
    #80;
  endtask

  task automatic testReset();
    chk("R1 codes", 32'(dacCode == '0), 1);
    chk("R1 enables", 32'(chanEn), 32'hF);
  endtask

  task automatic testHoldThenLoad();
    sendWord(frame(0, 0, 2'd0, 12'h123));
    chk("R4 held before load", 32'(code(0)), 0);
    pulseLoad();
    chk("R4 ch0 after load", 32'(code(0)), 32'h123);
  endtask

  task automatic testAddresses();
    sendWord(frame(0, 0, 2'd1, 12'h456));
    sendWord(frame(0, 0, 2'd2, 12'h789));
    sendWord(frame(0, 0, 2'd3, 12'hABC));
    chk("R5 ch3 held while load high", 32'(code(3)), 0);
    pulseLoad();
    chk("R4 ch0", 32'(code(0)), 32'h123);
    chk("R4 ch1", 32'(code(1)), 32'h456);
    chk("R4 ch2", 32'(code(2)), 32'h789);
    chk("R4 ch3", 32'(code(3)), 32'hABC);
  endtask

  task automatic testTransparent();
    loadN = 1'b0;
    sendWord(frame(0, 0, 2'd0, 12'h0F0));
    chk("R5 follows while low", 32'(code(0)), 32'h0F0);
    loadN = 1'b1;
    #80;
    sendWord(frame(0, 0, 2'd0, 12'h111));
    chk("R5 holds after high", 32'(code(0)), 32'h0F0);
    pulseLoad();
    chk("R5 next load", 32'(code(0)), 32'h111);
  endtask

  task automatic testFraming();
    logic [WW-1:0] w;
    w = frame(0, 0, 2'd1, 12'h2D3);
    selN = 1'b0;
    #40 clockBits(32'(w[15:8]), 8);
    #200 clockBits(32'(w[7:0]), 8);
    #40 selN = 1'b1;
    #120 pulseLoad();
    chk("R2 two bytes ch1", 32'(code(1)), 32'h2D3);
    sendBits({12'h0, 4'hF, frame(0, 0, 2'd2, 12'h0AA)}, WW + 4);
    pulseLoad();
    chk("R2 long frame ch2", 32'(code(2)), 32'h0AA);
    chk("R2 leading bits ignored", 32'(chanEn), 32'hF);
  endtask

  task automatic testSelectHigh();
    clockBits(32'(frame(0, 0, 2'd2, 12'hABC)), WW);
    selN = 1'b0;
    #80 selN = 1'b1;
    #120 pulseLoad();
    chk("R3 ch2 untouched", 32'(code(2)), 32'h0AA);
    chk("R3 ch1 untouched", 32'(code(1)), 32'h2D3);
  endtask

  task automatic testShutdown();
    sendWord(frame(0, 1, 2'd3, 12'h000));
    chk("R6 single off", 32'(chanEn), 32'h7);
    pulseLoad();
    chk("R6 code kept", 32'(code(3)), 32'hABC);
    sendWord(frame(1, 0, 2'd1, 12'hFFF));
    chk("R6 all off", 32'(chanEn), 32'h0);
    pulseLoad();
    chk("R6 all-off keeps ch1", 32'(code(1)), 32'h2D3);
  endtask

  task automatic testWake();
    sendWord(frame(0, 0, 2'd0, 12'h321));
    chk("R7 only ch0 wakes", 32'(chanEn), 32'h1);
    pulseLoad();
    chk("R7 ch0 code", 32'(code(0)), 32'h321);
  endtask

  task automatic testClear();
    sendWord(frame(0, 0, 2'd3, 12'h5A5));
    pulseLoad();
    #3 clearN = 1'b0;
    #4 chk("R8 codes cleared", 32'(dacCode == '0), 1);
    chk("R8 enables set", 32'(chanEn), 32'hF);
    #23 clearN = 1'b1;
    #10 selN = 1'b0;
    #80 selN = 1'b1;
    #120 pulseLoad();
    chk("R8 shift kept", 32'(code(3)), 32'h5A5);
    chk("R8 ch0 stays zero", 32'(code(0)), 0);
  endtask

  initial begin
    #50 porN = 1'b1;
    #50;
    testReset();
    testHoldThenLoad();
    testAddresses();
    testTransparent();
    testFraming();
    testSelectHigh();
    testShutdown();
    testWake();
    testClear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule